// File: doc/BRIEF.md
# Serial EEPROM Bus Slave Controller

This block is the bus-facing controller of a 2048-byte serial EEPROM. It watches an open-drain two-wire bus (a clock line and a data line, each oversampled by the system clock through a synchroniser) and answers as a slave. It decodes START and STOP conditions and the 7-bit device code with its read/write flag. It serves single-byte writes, current-address reads, random reads and sequential reads. The storage is a synchronous RAM array held inside the block.

A host write becomes a self-timed programming cycle. The cycle begins at the STOP that closes the write and runs for a fixed, parameterised number of clock cycles. For that whole time the controller leaves the bus untouched. A host can therefore poll for completion by sending START plus the write device byte until that byte is acknowledged. An internal address counter always points one past the most recently accessed byte. A write-protect input keeps the array read-only: the addresses are still acknowledged but the data byte is refused.

Top module: `serial_eeprom_ctrl`

## Requirements
- R1: After reset the block does not pull the data line low and the busy flag is 0.
- R2: A write transaction is START, device byte 1010000 followed by R/W = 0 (0xA0), a high address byte whose low 3 bits give address bits 10..8, a low address byte with address bits 7..0, then one data byte. The block acknowledges all four bytes, and at STOP the data byte is stored at that address.
- R3: A device byte whose upper 7 bits differ from 1010000 gets no acknowledge, and the block ignores the bus until the next START.
- R4: In a write, any data byte after the first is not acknowledged and is not stored.
- R5: A STOP that follows an acknowledged data byte raises the busy flag for PROG_CYCLES clock cycles. A STOP with no data byte pending leaves the flag low.
- R6: While busy the block never pulls the data line low, so its device byte is not acknowledged. Once the cycle ends, the device byte is acknowledged again.
- R7: The address counter holds the last accessed address plus one. A current-address read (START, 0xA1) returns the byte after the last one read or written.
- R8: A random read (dummy write of the two address bytes, repeated START, 0xA1) returns the byte at the newly loaded address.
- R9: In a read, a master acknowledge (data line low in the ninth clock) makes the block send the next byte. A master no-acknowledge ends the transfer and the line is released.
- R10: The address counter wraps from 2047 to 0, and a sequential read continues there with valid data.
- R11: With write protect high, the device byte and both address bytes are acknowledged, but the data byte is not. The memory is unchanged and no busy cycle starts.
- R12: The block changes its data-line drive only while the clock line is low. START is the data line falling while the clock is high, and STOP is the data line rising while the clock is high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock that oversamples the bus |
| rst_n | input | 1 | Active-low asynchronous reset |
| scl_i | input | 1 | Bus clock line as seen on the wire |
| sda_i | input | 1 | Bus data line as seen on the wire |
| sda_drive_low | output | 1 | 1 pulls the data line low (open-drain enable) |
| wp_i | input | 1 | Write protect; 1 makes the array read-only |
| prog_busy | output | 1 | High during the self-timed programming cycle |

## Verification
The hardest state to reach is a transaction that starts while the programming countdown is still running. Only a completed write with STOP can start that countdown, and the block gives no sign of it on the bus except missing acknowledges. The bench reaches it by issuing an acknowledge poll straight after each STOP, with the countdown shortened, and keeps polling until an acknowledge returns. Counter wrap is reached by a random read at address 2047 followed by a master acknowledge.

// File: rtl/eep_pkg.sv
package eep_pkg;

   typedef enum logic [3:0] {
      ST_IDLE,
      ST_DEV,
      ST_AHI,
      ST_ALO,
      ST_WDAT,
      ST_WTAIL,
      ST_ACK,
      ST_RD,
      ST_RD_ACK,
      ST_PROG
   } ctl_state_t;

   localparam int BYTE_W = 8;

endpackage

// File: rtl/eep_bus_sync.sv
module eep_bus_sync #(
   parameter int STAGES = 2
) (
   input  logic clk,
   input  logic rst_n,
   input  logic scl_raw,
   input  logic sda_raw,
   output logic scl_s,
   output logic sda_s,
   output logic scl_rise,
   output logic scl_fall,
   output logic start_det,
   output logic stop_det
);

   logic [STAGES-1:0] scl_chain;
   logic [STAGES-1:0] sda_chain;
   logic              scl_prev;
   logic              sda_prev;

   generate
      if (STAGES < 2) begin : g_bad_stages
         $error("eep_bus_sync: STAGES must be at least 2");
      end
      for (genvar i = 0; i < STAGES; i++) begin : g_stage
         if (i == 0) begin : g_first
            always_ff @(posedge clk or negedge rst_n) begin
               if (!rst_n) begin
                  scl_chain[0] <= 1'b1;
                  sda_chain[0] <= 1'b1;
               end else begin
                  scl_chain[0] <= scl_raw;
                  sda_chain[0] <= sda_raw;
               end
            end
         end else begin : g_next
            always_ff @(posedge clk or negedge rst_n) begin
               if (!rst_n) begin
                  scl_chain[i] <= 1'b1;
                  sda_chain[i] <= 1'b1;
               end else begin
                  scl_chain[i] <= scl_chain[i-1];
                  sda_chain[i] <= sda_chain[i-1];
               end
            end
         end
      end
   endgenerate

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         scl_prev <= 1'b1;
         sda_prev <= 1'b1;
      end else begin
         scl_prev <= scl_chain[STAGES-1];
         sda_prev <= sda_chain[STAGES-1];
      end
   end

   assign scl_s     = scl_chain[STAGES-1];
   assign sda_s     = sda_chain[STAGES-1];
   assign scl_rise  = scl_s && !scl_prev;
   assign scl_fall  = !scl_s && scl_prev;
   assign start_det = scl_s && scl_prev && sda_prev && !sda_s;
   assign stop_det  = scl_s && scl_prev && !sda_prev && sda_s;

endmodule

// File: rtl/eep_prog_timer.sv
module eep_prog_timer #(
   parameter int PROG_CYCLES = 5000
) (
   input  logic clk,
   input  logic rst_n,
   input  logic launch,
   output logic busy
);

   localparam int CW = $clog2(PROG_CYCLES + 1);

   logic [CW-1:0] remain_q;

   generate
      if (PROG_CYCLES < 1) begin : g_bad_cycles
         $error("eep_prog_timer: PROG_CYCLES must be at least 1");
      end
   endgenerate

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         remain_q <= '0;
      end else if (launch) begin
         remain_q <= CW'(PROG_CYCLES);
      end else if (remain_q != '0) begin
         remain_q <= remain_q - 1'b1;
      end
   end

   assign busy = (remain_q != '0);

endmodule

// File: rtl/eep_store.sv
module eep_store #(
   parameter int ADDR_W = 11
) (
   input  logic              clk,
   input  logic              we,
   input  logic [ADDR_W-1:0] addr,
   input  logic [7:0]        wdata,
   output logic [7:0]        rdata
);

   localparam int DEPTH = 1 << ADDR_W;

   logic [7:0] cells [DEPTH];

   always_ff @(posedge clk) begin
      if (we) begin
         cells[addr] <= wdata;
      end
      rdata <= cells[addr];
   end

endmodule

// File: rtl/serial_eeprom_ctrl.sv
module serial_eeprom_ctrl
   import eep_pkg::*;
#(
   parameter int         ADDR_W      = 11,
   parameter logic [6:0] DEV_CODE    = 7'b1010000,
   parameter int         PROG_CYCLES = 5000,
   parameter int         SYNC_STAGES = 2
) (
   input  logic clk,
   input  logic rst_n,
   input  logic scl_i,
   input  logic sda_i,
   output logic sda_drive_low,
   input  logic wp_i,
   output logic prog_busy
);

   localparam int HI_W = ADDR_W - BYTE_W;

   generate
      if (ADDR_W < 9 || ADDR_W > 16) begin : g_bad_addr
         $error("serial_eeprom_ctrl: ADDR_W must be 9..16");
      end
   endgenerate

   logic scl_s, sda_s, scl_rise, scl_fall, start_det, stop_det;

   eep_bus_sync #(.STAGES(SYNC_STAGES)) u_sync (
      .clk       (clk),
      .rst_n     (rst_n),
      .scl_raw   (scl_i),
      .sda_raw   (sda_i),
      .scl_s     (scl_s),
      .sda_s     (sda_s),
      .scl_rise  (scl_rise),
      .scl_fall  (scl_fall),
      .start_det (start_det),
      .stop_det  (stop_det)
   );

   ctl_state_t        state_q, after_ack_q;
   logic [7:0]        shift_q;
   logic [7:0]        tx_q;
   logic [7:0]        wbuf_q;
   logic [HI_W-1:0]   hi_q;
   logic [3:0]        bitcnt_q;
   logic              pend_q;
   logic              mack_q;
   logic              drive_q;
   logic [ADDR_W-1:0] addr_ctr;
   logic [7:0]        rd_byte;
   logic              mem_we;
   logic              timer_busy;
   logic              in_rx;
   logic              byte_end;

   assign mem_we   = stop_det && pend_q && (state_q != ST_PROG);
   assign in_rx    = (state_q == ST_DEV) || (state_q == ST_AHI) || (state_q == ST_ALO) ||
                     (state_q == ST_WDAT) || (state_q == ST_WTAIL);
   assign byte_end = in_rx && scl_fall && (bitcnt_q == 4'd8);

   eep_store #(.ADDR_W(ADDR_W)) u_store (
      .clk   (clk),
      .we    (mem_we),
      .addr  (addr_ctr),
      .wdata (wbuf_q),
      .rdata (rd_byte)
   );

   eep_prog_timer #(.PROG_CYCLES(PROG_CYCLES)) u_timer (
      .clk    (clk),
      .rst_n  (rst_n),
      .launch (mem_we),
      .busy   (timer_busy)
   );

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         state_q     <= ST_IDLE;
         after_ack_q <= ST_IDLE;
         shift_q     <= '0;
         tx_q        <= '0;
         wbuf_q      <= '0;
         hi_q        <= '0;
         bitcnt_q    <= '0;
         pend_q      <= 1'b0;
         mack_q      <= 1'b0;
         drive_q     <= 1'b0;
         addr_ctr    <= '0;
      end else if (state_q == ST_PROG) begin
         drive_q <= 1'b0;
         if (!timer_busy) begin
            state_q <= ST_IDLE;
         end
      end else if (stop_det) begin
         drive_q <= 1'b0;
         pend_q  <= 1'b0;
         if (pend_q) begin
            state_q  <= ST_PROG;
            addr_ctr <= addr_ctr + 1'b1;
         end else begin
            state_q <= ST_IDLE;
         end
      end else if (start_det) begin
         drive_q  <= 1'b0;
         pend_q   <= 1'b0;
         bitcnt_q <= '0;
         state_q  <= ST_DEV;
      end else begin
         if (in_rx && scl_rise) begin
            shift_q  <= {shift_q[6:0], sda_s};
            bitcnt_q <= bitcnt_q + 1'b1;
         end
         if (byte_end) begin
            bitcnt_q <= '0;
            unique case (state_q)
               ST_DEV: begin
                  if (shift_q[7:1] == DEV_CODE) begin
                     drive_q     <= 1'b1;
                     state_q     <= ST_ACK;
                     after_ack_q <= shift_q[0] ? ST_RD : ST_AHI;
                  end else begin
                     state_q <= ST_IDLE;
                  end
               end
               ST_AHI: begin
                  hi_q        <= shift_q[HI_W-1:0];
                  drive_q     <= 1'b1;
                  state_q     <= ST_ACK;
                  after_ack_q <= ST_ALO;
               end
               ST_ALO: begin
                  addr_ctr    <= {hi_q, shift_q};
                  drive_q     <= 1'b1;
                  state_q     <= ST_ACK;
                  after_ack_q <= ST_WDAT;
               end
               ST_WDAT: begin
                  if (wp_i) begin
                     state_q <= ST_WTAIL;
                  end else begin
                     wbuf_q      <= shift_q;
                     pend_q      <= 1'b1;
                     drive_q     <= 1'b1;
                     state_q     <= ST_ACK;
                     after_ack_q <= ST_WTAIL;
                  end
               end
               default: begin
                  state_q <= ST_WTAIL;
               end
            endcase
         end
         unique case (state_q)
            ST_ACK: begin
               if (scl_fall) begin
                  bitcnt_q <= '0;
                  state_q  <= after_ack_q;
                  if (after_ack_q == ST_RD) begin
                     tx_q     <= rd_byte;
                     drive_q  <= ~rd_byte[7];
                     addr_ctr <= addr_ctr + 1'b1;
                  end else begin
                     drive_q <= 1'b0;
                  end
               end
            end
            ST_RD: begin
               if (scl_fall) begin
                  if (bitcnt_q == 4'd7) begin
                     drive_q  <= 1'b0;
                     bitcnt_q <= '0;
                     state_q  <= ST_RD_ACK;
                  end else begin
                     tx_q     <= {tx_q[6:0], 1'b0};
                     drive_q  <= ~tx_q[6];
                     bitcnt_q <= bitcnt_q + 1'b1;
                  end
               end
            end
            ST_RD_ACK: begin
               if (scl_rise) begin
                  mack_q <= !sda_s;
               end
               if (scl_fall) begin
                  if (mack_q) begin
                     tx_q     <= rd_byte;
                     drive_q  <= ~rd_byte[7];
                     addr_ctr <= addr_ctr + 1'b1;
                     state_q  <= ST_RD;
                  end else begin
                     state_q <= ST_IDLE;
                  end
               end
            end
            default: ;
         endcase
      end
   end

   assign sda_drive_low = drive_q;
   assign prog_busy     = timer_busy;

endmodule

// File: rtl/serial_eeprom_ctrl_chk.sv
module serial_eeprom_ctrl_chk #(
   parameter int ADDR_W = 11
) (
   input logic              clk,
   input logic              rst_n,
   input logic              scl_s,
   input logic              sda_drive_low,
   input logic              prog_busy,
   input logic              mem_we,
   input logic [ADDR_W-1:0] addr_ctr
);

   // R6
   busy_silent_chk: assert property (@(posedge clk) disable iff (!rst_n)
      prog_busy |-> !sda_drive_low);

   // R5
   write_starts_busy_chk: assert property (@(posedge clk) disable iff (!rst_n)
      mem_we |=> prog_busy);

   // R7
   ctr_step_chk: assert property (@(posedge clk) disable iff (!rst_n)
      mem_we |=> (addr_ctr == ADDR_W'($past(addr_ctr) + 1'b1)));

   // R12
   drive_edge_chk: assert property (@(posedge clk) disable iff (!rst_n)
      !$stable(sda_drive_low) |-> !scl_s);

endmodule

bind serial_eeprom_ctrl serial_eeprom_ctrl_chk #(.ADDR_W(ADDR_W)) u_chk (
   .clk           (clk),
   .rst_n         (rst_n),
   .scl_s         (scl_s),
   .sda_drive_low (sda_drive_low),
   .prog_busy     (prog_busy),
   .mem_we        (mem_we),
   .addr_ctr      (addr_ctr)
);

// File: tb/serial_eeprom_ctrl_test.sv
module serial_eeprom_ctrl_test;

   localparam int PROG = 600;
   localparam int H    = 10;
   localparam int Q    = 4;

   typedef struct {
      logic [7:0] val;
      string      req;
   } exp_t;

   logic clk = 1'b0;
   logic rst_n = 1'b0;
   logic scl = 1'b1;
   logic host_low = 1'b0;
   logic wp = 1'b0;
   logic sda_drive_low, prog_busy;
   wire  sda_line = !(host_low || sda_drive_low);

   int   n_checks = 0;
   int   n_fail = 0;
   int   edge_viol = 0;
   exp_t exp_q[$];
   logic [7:0] act_q[$];

   always #2.5 clk = ~clk;

   serial_eeprom_ctrl #(.PROG_CYCLES(PROG)) uut (
      .clk           (clk),
      .rst_n         (rst_n),
      .scl_i         (scl),
      .sda_i         (sda_line),
      .sda_drive_low (sda_drive_low),
      .wp_i          (wp),
      .prog_busy     (prog_busy)
   );

   task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
      n_checks++;
      if (act !== exp) begin
         n_fail++;
         $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
      end
   endtask

   // monitor: scoreboard compare of read bytes
   initial begin
      forever begin
         @(negedge clk);
         while (act_q.size() > 0) begin
            logic [7:0] a;
            a = act_q.pop_front();
            if (exp_q.size() == 0) begin
               check("scoreboard-extra", {24'd0, a}, 32'hFFFF);
            end else begin
               exp_t e;
               e = exp_q.pop_front();
               check(e.req, {24'd0, a}, {24'd0, e.val});
            end
         end
      end
   end

   // R12: device drive may only change while SCL is low
   logic prev_drive = 1'b0;
   always @(negedge clk) begin
      if (rst_n && (sda_drive_low !== prev_drive) && scl) edge_viol++;
      prev_drive <= sda_drive_low;
   end

   task automatic cyc(input int n);
      repeat (n) @(posedge clk);
      #1;
   endtask

   task automatic bus_start();
      host_low = 1'b0; cyc(H);
      scl = 1'b1; cyc(H);
      host_low = 1'b1; cyc(H);
      scl = 1'b0; cyc(Q);
   endtask

   task automatic bus_stop();
      host_low = 1'b1; cyc(H);
      scl = 1'b1; cyc(H);
      host_low = 1'b0; cyc(H);
   endtask

   task automatic send_byte(input logic [7:0] b, output logic ack);
      for (int i = 7; i >= 0; i--) begin
         host_low = ~b[i]; cyc(H);
         scl = 1'b1; cyc(H);
         scl = 1'b0; cyc(Q);
      end
      host_low = 1'b0; cyc(H);
      scl = 1'b1; cyc(H/2);
      ack = !sda_line; cyc(H/2);
      scl = 1'b0; cyc(Q);
   endtask

   task automatic recv_byte(input logic master_ack);
      logic [7:0] b;
      host_low = 1'b0;
      for (int i = 7; i >= 0; i--) begin
         cyc(H);
         scl = 1'b1; cyc(H/2);
         b[i] = sda_line; cyc(H/2);
         scl = 1'b0; cyc(Q);
      end
      act_q.push_back(b);
      host_low = master_ack; cyc(H);
      scl = 1'b1; cyc(H);
      scl = 1'b0; cyc(Q);
      host_low = 1'b0;
   endtask

   task automatic expect_byte(input logic [7:0] v, input string req);
      exp_t e;
      e.val = v;
      e.req = req;
      exp_q.push_back(e);
   endtask

   task automatic set_addr(input logic [10:0] a, input string req);
      logic ack;
      bus_start();
      send_byte(8'hA0, ack); check({req, " dev ack"}, ack, 1);
      send_byte({5'd0, a[10:8]}, ack); check({req, " hi ack"}, ack, 1);
      send_byte(a[7:0], ack); check({req, " lo ack"}, ack, 1);
   endtask

   task automatic wait_ready(input string req);
      logic ack;
      int   tries = 0;
      ack = 1'b0;
      while (!ack && tries < 40) begin
         bus_start();
         send_byte(8'hA0, ack);
         bus_stop();
         tries++;
      end
      check({req, " ready after poll"}, ack, 1);
   endtask

   task automatic write_byte(input logic [10:0] a, input logic [7:0] d);
      logic ack;
      set_addr(a, "R2");
      send_byte(d, ack); check("R2 data ack", ack, 1);
      bus_stop();
      check("R5 busy after STOP", prog_busy, 1);
      wait_ready("R6");
   endtask

   task automatic rand_read(input logic [10:0] a);
      logic ack;
      set_addr(a, "R8");
      bus_start();
      send_byte(8'hA1, ack); check("R8 read dev ack", ack, 1);
   endtask

   initial begin
      logic ack;
      cyc(10);
      rst_n = 1'b1;
      cyc(3);
      check("R1 drive released", sda_drive_low, 0);
      check("R1 not busy", prog_busy, 0);

      // R5/R6 busy timing and polling
      set_addr(11'h124, "R2");
      send_byte(8'hC3, ack); check("R2 data ack", ack, 1);
      bus_stop();
      check("R5 busy raised", prog_busy, 1);
      bus_start();
      send_byte(8'hA0, ack);
      check("R6 no ack while busy", ack, 0);
      bus_stop();
      wait_ready("R6");
      check("R5 busy cleared", prog_busy, 0);

      write_byte(11'h123, 8'h5A);
      write_byte(11'h7FF, 8'h11);
      write_byte(11'h000, 8'h22);
      write_byte(11'h001, 8'h33);
      write_byte(11'h201, 8'h66);

      // R4: second data byte refused
      set_addr(11'h200, "R4");
      send_byte(8'h44, ack); check("R4 first data ack", ack, 1);
      send_byte(8'h55, ack); check("R4 second data nack", ack, 0);
      bus_stop();
      wait_ready("R4");
      // R7: counter is 0x201 after write to 0x200
      bus_start();
      send_byte(8'hA1, ack); check("R7 cur dev ack", ack, 1);
      expect_byte(8'h66, "R7 current after write (R4 not stored)");
      recv_byte(1'b0);
      bus_stop();

      // R8 then R7
      rand_read(11'h123);
      expect_byte(8'h5A, "R8 random read");
      recv_byte(1'b0);
      bus_stop();
      check("R9 released after NACK", sda_drive_low, 0);
      bus_start();
      send_byte(8'hA1, ack); check("R7 cur dev ack", ack, 1);
      expect_byte(8'hC3, "R7 current read N+1");
      recv_byte(1'b0);
      bus_stop();

      // R9/R10 sequential with wrap
      rand_read(11'h7FF);
      expect_byte(8'h11, "R9 seq first");
      recv_byte(1'b1);
      expect_byte(8'h22, "R10 wrap to 0");
      recv_byte(1'b0);
      bus_stop();
      bus_start();
      send_byte(8'hA1, ack); check("R10 cur dev ack", ack, 1);
      expect_byte(8'h33, "R10 counter after wrap");
      recv_byte(1'b0);
      bus_stop();

      // R4 sequential seq through 0x200
      rand_read(11'h200);
      expect_byte(8'h44, "R4 stored first");
      recv_byte(1'b1);
      expect_byte(8'h66, "R4 second not stored");
      recv_byte(1'b0);
      bus_stop();

      // R3 wrong device code
      bus_start();
      send_byte(8'hB0, ack); check("R3 foreign code nack", ack, 0);
      send_byte(8'h00, ack); check("R3 ignored after", ack, 0);
      bus_stop();

      // R11 write protect
      wp = 1'b1;
      set_addr(11'h123, "R11");
      send_byte(8'hFF, ack); check("R11 data nack", ack, 0);
      bus_stop();
      check("R11 no busy", prog_busy, 0);
      wp = 1'b0;
      rand_read(11'h123);
      expect_byte(8'h5A, "R11 memory unchanged");
      recv_byte(1'b0);
      bus_stop();

      cyc(20);
      check("R12 drive changed only with SCL low", edge_viol, 0);
      check("scoreboard drained", exp_q.size(), 0);
      $display("  [TB] %0d tests run, %0d failed", n_checks, n_fail);
      $finish;
   end

   initial begin
      repeat (190000) @(posedge clk);
      n_checks++;
      n_fail++;
      $display("FAIL watchdog actual=timeout expected=done");
      $display("  [TB] %0d tests run, %0d failed", n_checks, n_fail);
      $finish;
   end

endmodule